// File: doc/BRIEF.md
# Quad I/O Continuous-Read Engine

This block is the read side of a serial NOR flash target. A host lowers chip select, sends a one-line read opcode, then a 24-bit address and an 8-bit mode byte four bits per clock. After a fixed number of dummy clocks, the block streams bytes from a small memory array back on the same four lines, one nibble per clock. The address advances after every byte, so a single transaction can run through the whole array.

The mode byte controls the next transaction. If its upper nibble is hex A, the next transaction skips the opcode and starts with the address. Only 6 address clocks plus 2 mode clocks then come before the dummy clocks. Any other upper nibble returns the engine to opcode decoding. Opcode FFh also leaves the continuous state. In the continuous state, a first address byte of FFh does the same.

The block has no storage of its own. It presents an address to an asynchronous memory read port and drives the returned byte out as two nibbles.

Top module: `qio_xip_reader`

## Requirements
- R1: Inputs are sampled on rising edges of `sck`, and `io_out`/`io_oe` change only on falling edges. A driven nibble therefore stays stable across the rising edge that follows it.
- R2: In the normal state, a transaction starts with an 8-bit opcode on `io_in[0]`, MSB first. Opcode EBh is then followed by 6 address nibbles, MSB nibble first, with bit 3 of each nibble on `io_in[3]`.
- R3: Two mode nibbles follow the address. If the first (upper) nibble is Ah, the next transaction starts directly with the address nibbles and has no opcode. The second mode nibble has no effect.
- R4: A mode byte whose upper nibble is not Ah returns the engine to the normal state, where the next transaction must start with an opcode.
- R5: After the mode byte, `DUMMY` rising edges pass with `io_oe` = 0. The first data nibble is driven on the falling edge after the last dummy rising edge, and `io_oe` is then all ones (4'hF) for the whole data phase.
- R6: Each byte is sent upper nibble first, then lower nibble. The read address increments after each byte and wraps modulo 2^`AW`.
- R7: Opcode FFh, or in the continuous state a first address byte of FFh, clears the continuous state and produces no data for that transaction.
- R8: Raising `cs_n` at any point aborts the transfer and forces `io_oe` to 0 at once. The continuous state changes only when a complete mode byte has been received (or under R7).
- R9: Any opcode other than EBh and FFh is ignored: no data is driven during that transaction.
- R10: After `rst_n` is low, the engine is in the normal state with `io_oe` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Active-low reset of the continuous-state flag and all logic |
| sck | input | 1 | Serial clock |
| cs_n | input | 1 | Active-low chip select; high aborts the transfer |
| io_in | input | 4 | Data lines as seen by the block |
| io_out | output | 4 | Data nibble driven toward the host |
| io_oe | output | 4 | Per-line output enable (all zero or all one) |
| mem_addr | output | AW | Byte address to the memory read port |
| mem_rdata | input | 8 | Byte returned by the memory for `mem_addr` |

## Verification
A wrong continuous-state flag does not show in the transaction that corrupts it. It shows in the next one: a header sent without an opcode either returns data when it should be silent, or stays silent when it should return data. A miscounted shift or dummy counter moves the first data nibble by one half clock or more, so the first sampled nibble or enable is already wrong. An address-increment fault appears on the second byte of any read. A wrap fault appears only when a read crosses the top of the array.

// File: rtl/qio_xip_reader.sv
module qio_xip_reader #(
  parameter int AW      = 8,
  parameter int DUMMY   = 4,
  parameter logic [7:0] OP_READ = 8'hEB,
  parameter logic [7:0] OP_EXIT = 8'hFF
) (
  input  logic          rst_n,
  input  logic          sck,
  input  logic          cs_n,
  input  logic [3:0]    io_in,
  output logic [3:0]    io_out,
  output logic [3:0]    io_oe,
  output logic [AW-1:0] mem_addr,
  input  logic [7:0]    mem_rdata
);
  localparam int CW = $clog2(DUMMY + 9);
  localparam logic [CW-1:0] DLAST = CW'((DUMMY > 0) ? DUMMY - 1 : 0);

  typedef enum logic [2:0] {S_START, S_OPC, S_ADDR, S_MODE, S_DUM, S_DATA, S_IGN} st_t;

  st_t           state;
  logic [CW-1:0] cnt;
  logic [7:0]    op;
  logic [23:0]   addr;
  logic [3:0]    mode_hi;
  logic          skip, lo, cont_q;

  wire       clr    = cs_n | ~rst_n;
  wire [7:0] op_nx  = {op[6:0], io_in[0]};
  wire       ff_hdr = skip && (state == S_ADDR) && (cnt == CW'(1)) && ({addr[3:0], io_in} == 8'hFF);

  assign mem_addr = addr[AW-1:0];

  always_ff @(posedge sck or posedge clr) begin
    if (clr) begin
      state   <= S_START;
      cnt     <= '0;
      op      <= '0;
      addr    <= '0;
      mode_hi <= '0;
      skip    <= 1'b0;
      lo      <= 1'b0;
    end else begin
      case (state)
        S_START: begin
          cnt <= CW'(1);
          if (cont_q) begin
            addr  <= {20'd0, io_in};
            skip  <= 1'b1;
            state <= S_ADDR;
          end else begin
            op    <= {7'd0, io_in[0]};
            state <= S_OPC;
          end
        end
        S_OPC: begin
          op  <= op_nx;
          cnt <= cnt + 1'b1;
          if (cnt == CW'(7)) begin
            cnt   <= '0;
            state <= (op_nx == OP_READ) ? S_ADDR : S_IGN;
          end
        end
        S_ADDR: begin
          addr <= {addr[19:0], io_in};
          cnt  <= cnt + 1'b1;
          if (ff_hdr) state <= S_IGN;
          else if (cnt == CW'(5)) begin
            cnt   <= '0;
            state <= S_MODE;
          end
        end
        S_MODE: begin
          cnt <= cnt + 1'b1;
          if (cnt == '0) mode_hi <= io_in;
          else begin
            cnt   <= '0;
            state <= (DUMMY == 0) ? S_DATA : S_DUM;
          end
        end
        S_DUM: begin
          cnt <= cnt + 1'b1;
          if (cnt == DLAST) state <= S_DATA;
        end
        S_DATA: begin
          lo <= ~lo;
          if (lo) addr <= addr + 24'd1;
        end
        default: state <= S_IGN;
      endcase
    end
  end

  always_ff @(posedge sck or negedge rst_n) begin
    if (!rst_n) cont_q <= 1'b0;
    else if (!cs_n) begin
      if (state == S_MODE && cnt == CW'(1)) cont_q <= (mode_hi == 4'hA);
      else if (state == S_OPC && cnt == CW'(7) && op_nx == OP_EXIT) cont_q <= 1'b0;
      else if (ff_hdr) cont_q <= 1'b0;
    end
  end

  always_ff @(negedge sck or posedge clr) begin
    if (clr) begin
      io_out <= '0;
      io_oe  <= '0;
    end else if (state == S_DATA) begin
      io_out <= lo ? mem_rdata[3:0] : mem_rdata[7:4];
      io_oe  <= 4'hF;
    end else begin
      io_out <= '0;
      io_oe  <= '0;
    end
  end

  assert_dummy_quiet_R5: assert property (@(posedge sck) disable iff (!rst_n || cs_n)
    (state == S_DUM) |-> (io_oe == 4'h0));

  assert_addr_step_R6: assert property (@(posedge sck) disable iff (!rst_n || cs_n)
    (state == S_DATA && lo) |=> (addr == $past(addr) + 24'd1));

  assert_abort_release_R8: assert property (@(negedge sck) disable iff (!rst_n)
    cs_n |-> (io_oe == 4'h0));

  assert_skip_opcode_R3: assert property (@(posedge sck) disable iff (!rst_n || cs_n)
    (state == S_START && cont_q) |=> (state == S_ADDR));

  always_comb begin
    assert_oe_whole_R5: assert (io_oe == 4'h0 || io_oe == 4'hF);
  end
endmodule

// File: tb/qio_xip_reader_tb.sv
module qio_xip_reader_tb;
  localparam int DUMMY = 4;
  logic rst_n = 1'b0, sck = 1'b0, cs_n = 1'b1;
  logic [3:0] io_in = '0;
  logic [3:0] io_out, io_oe;
  logic [7:0] mem_addr, mem_rdata;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 sck = ~sck;
  assign mem_rdata = 8'(mem_addr * 29 + 5);

  qio_xip_reader #(.AW(8), .DUMMY(DUMMY)) u_dut (
    .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .io_in(io_in), .io_out(io_out),
    .io_oe(io_oe), .mem_addr(mem_addr), .mem_rdata(mem_rdata));

  function automatic logic [7:0] mval(input int a);
    return 8'((a % 256) * 29 + 5);
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drv(input logic [3:0] nib, input bit first);
    @(negedge sck); #1;
    if (first) cs_n = 1'b0;
    io_in = nib;
  endtask

  task automatic hdr(input bit with_op, input logic [7:0] op, input logic [23:0] a, input logic [7:0] m);
    for (int i = 0; i < 8; i++) if (with_op) drv({3'b0, op[7-i]}, i == 0);
    for (int k = 0; k < 6; k++) drv(a[23-4*k -: 4], !with_op && k == 0);
    drv(m[7:4], 0);
    drv(m[3:0], 0);
    for (int d = 0; d < DUMMY; d++) drv(4'h0, 0);
    #1 chk("R5 oe low in dummy", {4'h0, io_oe}, 8'h00);
  endtask

  task automatic rd(input int a, input int n);
    for (int j = 0; j < n; j++) begin
      @(negedge sck); #2;
      chk("R5 oe in data", {4'h0, io_oe}, 8'h0F);
      chk("R2 R6 high nibble", {4'h0, io_out}, {4'h0, mval(a + j)} >> 4);
      @(posedge sck); #1;
      chk("R1 stable at rising", {4'h0, io_out}, {4'h0, mval(a + j)} >> 4);
      @(negedge sck); #2;
      chk("R6 low nibble", {4'h0, io_out}, {4'h0, mval(a + j) & 8'h0F});
    end
  endtask

  task automatic quiet(input string tag, input int n);
    for (int j = 0; j < n; j++) begin
      @(negedge sck); #2;
      chk(tag, {4'h0, io_oe}, 8'h00);
    end
  endtask

  task automatic stop_x();
    @(negedge sck); #1;
    cs_n = 1'b1; io_in = '0;
    #1 chk("R8 oe off after cs high", {4'h0, io_oe}, 8'h00);
    repeat (2) @(negedge sck);
  endtask

  task automatic probe(input bit expect_data);
    hdr(0, 8'h00, 24'h000040, 8'h00);
    if (expect_data) rd(8'h40, 1); else quiet("R4 no data without opcode", 3);
    stop_x();
  endtask

  initial begin
    repeat (3) @(negedge sck);
    #1 chk("R10 oe at reset", {4'h0, io_oe}, 8'h00);
    rst_n = 1'b1;
    repeat (2) @(negedge sck);
    probe(0);                                    // R10 normal state after reset
    hdr(1, 8'hEB, 24'h000010, 8'h00); rd(8'h10, 4); stop_x();          // R2
    hdr(1, 8'hEB, 24'h0000FE, 8'hA5); rd(8'hFE, 4); stop_x();          // R6 wrap, R3 set
    hdr(0, 8'h00, 24'h000033, 8'hA0); rd(8'h33, 3); stop_x();          // R3
    hdr(0, 8'h00, 24'h000077, 8'h5A); rd(8'h77, 2); stop_x();          // R4 clear
    probe(0);                                                          // R4
    hdr(1, 8'h03, 24'h000010, 8'h00); quiet("R9 other opcode", 4); stop_x();
    // R8: abort mid-address keeps continuous state
    hdr(1, 8'hEB, 24'h000020, 8'hAF); rd(8'h20, 1); stop_x();
    drv(4'h0, 1); drv(4'h0, 0); drv(4'h1, 0); stop_x();
    hdr(0, 8'h00, 24'h000021, 8'hA0); rd(8'h21, 1); stop_x();
    // R8: half mode byte does not update the flag
    for (int k = 0; k < 6; k++) drv(4'h0, k == 0);
    drv(4'h5, 0); stop_x();
    hdr(0, 8'h00, 24'h000022, 8'h00); rd(8'h22, 1); stop_x();
    probe(0);
    // R7: all-ones header in continuous state
    hdr(1, 8'hEB, 24'h000030, 8'hA0); rd(8'h30, 1); stop_x();
    for (int i = 0; i < 8; i++) drv(4'hF, i == 0);
    quiet("R7 no data on exit", 2); stop_x();
    probe(0);
    // R7: opcode FF in normal state is harmless
    for (int i = 0; i < 8; i++) drv(4'hF, i == 0);
    quiet("R7 no data for FF", 2); stop_x();
    hdr(1, 8'hEB, 24'h000044, 8'h00); rd(8'h44, 2); stop_x();
    // R3 R4: sweep of the mode upper nibble
    for (int m = 0; m < 16; m++) begin
      hdr(1, 8'hEB, 24'h000050, 8'hA0); rd(8'h50, 1); stop_x();
      hdr(0, 8'h00, 24'(m * 5), {4'(m), ~4'(m)}); rd(m * 5, 2); stop_x();
      probe(m == 10);
    end
    // R6: address sweep in continuous state
    hdr(1, 8'hEB, 24'h000000, 8'hA0); rd(0, 1); stop_x();
    for (int a = 0; a < 32; a++) begin
      hdr(0, 8'h00, 24'(a * 8 + 3), 8'hA0); rd(a * 8 + 3, 2); stop_x();
    end
    hdr(0, 8'h00, 24'h0000FF, 8'h00); rd(8'hFF, 2); stop_x();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge sck);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule